// File: doc/BRIEF.md
# Interrupt Gateway and Claim/Complete Arbiter

This block collects interrupt lines from a set of sources and presents them to one handling target. Each source has its own gateway, which turns a level-sensitive or edge-sensitive input line into requests. A shared core keeps one pending flag and one claimed flag per source, plus a programmable priority for each source. Source IDs run from 1 to NSRC, and ID 0 means "no source".

Software on the target reacts to `irq_o` by pulsing `claim_i`. In the same cycle, `claim_id_o` returns the ID of the highest-priority pending source. That source then stops being pending and becomes claimed. When the handler is done, it writes that ID with `complete_i`, which releases the source.

A level-triggered source whose line is still high at completion raises a fresh request at once. Without that step, a level source would act like an edge source. An edge-triggered source keeps at most one extra rising edge that arrives while it is being serviced, and delivers it at completion.

Top module: `irqc_claim_ctrl`

## Requirements
- R1: While `claim_i` is high, `claim_id_o` combinationally returns the ID (source index + 1) of the pending source with the largest nonzero priority.
- R2: Equal priorities go to the lowest ID. A source whose priority is 0 is never returned by a claim and never raises `irq_o`.
- R3: A claim that returns a nonzero ID clears that source's pending flag and marks it claimed at the same clock edge. A claimed source is not made pending again before its completion.
- R4: A claim that finds no eligible source returns 0 and changes no pending or claimed flag.
- R5: A source is level-triggered when its `edge_mode_i` bit is 0. If its line is high in the completion cycle, the source is pending again at the completion edge.
- R6: A level-triggered source whose line is high while it is not claimed becomes pending. If its line has dropped by completion, no new request is made.
- R7: A source is edge-triggered when its `edge_mode_i` bit is 1. It makes one request per rising edge of its line, and a line held high makes no more requests. Any number of rising edges during its claimed period collapse into one deferred request, which becomes pending at the completion edge.
- R8: A completion whose ID is not currently claimed, including ID 0 and IDs above NSRC, has no effect.
- R9: `irq_o` is high exactly when some pending source has nonzero priority.
- R10: A request that coincides with the claim of the same source is not lost. An edge request is deferred to the completion. A level request is raised again at completion if the line is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | NSRC | Interrupt line of each source; bit k belongs to ID k+1 |
| edge_mode_i | input | NSRC | Trigger select per source: 1 = edge, 0 = level |
| prio_we_i | input | 1 | Priority write strobe |
| prio_id_i | input | ID_W | Source ID whose priority is written |
| prio_val_i | input | PRIO_W | Priority value to write |
| claim_i | input | 1 | Claim strobe |
| claim_id_o | output | ID_W | ID granted by the claim in this cycle, 0 if none |
| complete_i | input | 1 | Completion strobe |
| complete_id_i | input | ID_W | ID being completed |
| irq_o | output | 1 | Interrupt request to the target |

## Verification
The arbitration is tried with three patterns, and each one separates a different fault.

- Two level sources share the top priority alongside a lower one. This shows whether the tie breaks to the lowest ID and whether the claim order follows priority.
- A source with priority 0 is left pending. This shows whether zero priority is really masked from both `claim_id_o` and `irq_o`.
- Completions are issued with the line still high and with it dropped. This separates a real level re-forward from edge-like behaviour.

Bursts of edges inside a claimed window, and a rising edge in the exact claim cycle, show whether deferred edges are merged into one and kept. A completion to an unclaimed ID checks that such a write cannot release a different source.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;
endpackage

// File: rtl/irqc_gateway.sv
module irqc_gateway
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic mode_i,
  input  logic claimed_i,
  input  logic claim_hit_i,
  input  logic cpl_hit_i,
  output logic fwd_o
);
  trig_e mode;
  logic  line_q;
  logic  held_q;
  logic  rise;
  logic  want;

  assign mode = trig_e'(mode_i);
  assign rise = line_i & ~line_q;

  always_comb begin
    if (mode == TRIG_LEVEL) begin
      want = line_i && (!claimed_i || cpl_hit_i);
    end else begin
      want = (rise && !claimed_i) || (cpl_hit_i && (held_q || rise));
    end
  end

  // a request colliding with the claim of this source is not taken as pending
  assign fwd_o = want && !claim_hit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      line_q <= line_i;
      if (cpl_hit_i) begin
        held_q <= 1'b0;
      end else if (mode == TRIG_EDGE && rise && (claimed_i || claim_hit_i)) begin
        held_q <= 1'b1;
      end
    end
  end

  AST_GW_QUIET_WHILE_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (claimed_i && !cpl_hit_i) |-> !fwd_o); // R3

  AST_GW_DEFERRED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_hit_i && mode_i && held_q) |-> fwd_o); // R7
endmodule

// File: rtl/irqc_prio_bank.sv
module irqc_prio_bank #(
  parameter int NSRC   = 7,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [ID_W-1:0]        id_i,
  input  logic [PRIO_W-1:0]      val_i,
  output logic [NSRC*PRIO_W-1:0] prio_flat_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_reg
    logic [PRIO_W-1:0] prio_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_q <= '0;
      end else if (we_i && id_i == ID_W'(k + 1)) begin
        prio_q <= val_i;
      end
    end
    assign prio_flat_o[k*PRIO_W +: PRIO_W] = prio_q;
  end
endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int NSRC   = 7,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 3
) (
  input  logic [NSRC-1:0]        pend_i,
  input  logic [NSRC*PRIO_W-1:0] prio_flat_i,
  output logic [ID_W-1:0]        best_id_o,
  output logic                   any_o
);
  // strict "greater": an equal priority seen later in the ascending scan loses
  function automatic logic outranks(input logic [PRIO_W-1:0] cand,
                                    input logic [PRIO_W-1:0] cur);
    return cand > cur;
  endfunction

  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_p    = '0;
    best_id_o = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (pend_i[k] && outranks(prio_flat_i[k*PRIO_W +: PRIO_W], best_p)) begin
        best_p    = prio_flat_i[k*PRIO_W +: PRIO_W];
        best_id_o = ID_W'(k + 1);
      end
    end
    any_o = (best_id_o != '0);
  end
endmodule

// File: rtl/irqc_claim_ctrl.sv
module irqc_claim_ctrl #(
  parameter int NSRC   = 7,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   line_i,
  input  logic [NSRC-1:0]   edge_mode_i,
  input  logic              prio_we_i,
  input  logic [ID_W-1:0]   prio_id_i,
  input  logic [PRIO_W-1:0] prio_val_i,
  input  logic              claim_i,
  output logic [ID_W-1:0]   claim_id_o,
  input  logic              complete_i,
  input  logic [ID_W-1:0]   complete_id_i,
  output logic              irq_o
);
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NSRC-1:0]        pending_q;
  logic [NSRC-1:0]        claimed_q;
  logic [NSRC-1:0]        claim_hit;
  logic [NSRC-1:0]        cpl_hit;
  logic [NSRC-1:0]        fwd;
  logic [ID_W-1:0]        best_id;
  logic                   any_elig;

  irqc_prio_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_prio (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (prio_we_i),
    .id_i        (prio_id_i),
    .val_i       (prio_val_i),
    .prio_flat_o (prio_flat)
  );

  irqc_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
    .pend_i      (pending_q),
    .prio_flat_i (prio_flat),
    .best_id_o   (best_id),
    .any_o       (any_elig)
  );

  assign claim_id_o = claim_i ? best_id : '0;
  assign irq_o      = any_elig;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign claim_hit[k] = claim_i && any_elig && best_id == ID_W'(k + 1);
    assign cpl_hit[k]   = complete_i && complete_id_i == ID_W'(k + 1) && claimed_q[k];

    irqc_gateway u_gw (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_i      (line_i[k]),
      .mode_i      (edge_mode_i[k]),
      .claimed_i   (claimed_q[k]),
      .claim_hit_i (claim_hit[k]),
      .cpl_hit_i   (cpl_hit[k]),
      .fwd_o       (fwd[k])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending_q[k] <= 1'b0;
        claimed_q[k] <= 1'b0;
      end else begin
        pending_q[k] <= (pending_q[k] && !claim_hit[k]) || fwd[k];
        claimed_q[k] <= (claimed_q[k] || claim_hit[k]) && !cpl_hit[k];
      end
    end

    AST_CLAIM_TAKES_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      claim_hit[k] |=> (claimed_q[k] && !pending_q[k])); // R3

    AST_PEND_CLAIM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(pending_q[k] && claimed_q[k])); // R3

    AST_LEVEL_REFORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_hit[k] && !edge_mode_i[k] && line_i[k]) |=> pending_q[k]); // R5
  end

  AST_EMPTY_CLAIM_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_i && claim_id_o == '0 && !complete_i) |=> (claimed_q == $past(claimed_q))); // R4

  AST_STRAY_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_i && !claim_i && $countones(cpl_hit) == 0) |=> (claimed_q == $past(claimed_q))); // R8

  AST_CLAIM_GRANTS_WHEN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_i && irq_o) |-> (claim_id_o != '0)); // R9

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_hit)); // R1
endmodule

// File: tb/tb_irqc_claim_ctrl.sv
module tb_irqc_claim_ctrl;
  localparam int NSRC   = 7;
  localparam int PRIO_W = 3;
  localparam int ID_W   = $clog2(NSRC + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC-1:0]   line_i = '0;
  logic [NSRC-1:0]   edge_mode_i = 7'b1101000; // IDs 4,6,7 edge; others level
  logic              prio_we_i = 1'b0;
  logic [ID_W-1:0]   prio_id_i = '0;
  logic [PRIO_W-1:0] prio_val_i = '0;
  logic              claim_i = 1'b0;
  logic [ID_W-1:0]   claim_id_o;
  logic              complete_i = 1'b0;
  logic [ID_W-1:0]   complete_id_i = '0;
  logic              irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  irqc_claim_ctrl #(.NSRC(NSRC), .PRIO_W(PRIO_W)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_i        (line_i),
    .edge_mode_i   (edge_mode_i),
    .prio_we_i     (prio_we_i),
    .prio_id_i     (prio_id_i),
    .prio_val_i    (prio_val_i),
    .claim_i       (claim_i),
    .claim_id_o    (claim_id_o),
    .complete_i    (complete_i),
    .complete_id_i (complete_id_i),
    .irq_o         (irq_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // monitor: compare the granted ID in every claim cycle with the scoreboard
  always @(negedge clk) begin
    if (rst_n && claim_i) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL scoreboard: got %0d expected none", claim_id_o);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(claim_id_o), e, t);
      end
    end
  end

  task automatic do_claim(input int exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    claim_i = 1'b1;
    tick();
    claim_i = 1'b0;
  endtask

  task automatic do_complete(input int id);
    complete_i    = 1'b1;
    complete_id_i = ID_W'(id);
    tick();
    complete_i    = 1'b0;
  endtask

  task automatic set_prio(input int id, input int p);
    prio_we_i  = 1'b1;
    prio_id_i  = ID_W'(id);
    prio_val_i = PRIO_W'(p);
    tick();
    prio_we_i  = 1'b0;
  endtask

  task automatic pulse(input int id);
    line_i[id-1] = 1'b1;
    tick();
    line_i[id-1] = 1'b0;
    tick();
  endtask

  task automatic finish_run();
    chk(exp_q.size(), 0, "scoreboard drained");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(irq_o, 0, "R9 reset irq");
    do_claim(0, "R4 claim after reset");

    set_prio(1, 2); set_prio(2, 5); set_prio(3, 5); set_prio(4, 1);
    set_prio(5, 0); set_prio(6, 3); set_prio(7, 7);

    // priority 0 source stays pending but is masked
    line_i[4] = 1'b1; tick(); line_i[4] = 1'b0; tick();
    chk(irq_o, 0, "R2 prio0 no irq");
    do_claim(0, "R2 prio0 never granted");

    // level sources: tie and ordering
    line_i[0] = 1'b1; line_i[1] = 1'b1; line_i[2] = 1'b1;
    tick();
    chk(irq_o, 1, "R9 irq with pending");
    do_claim(2, "R2 tie to lowest ID");
    do_claim(3, "R1 next highest");
    do_claim(1, "R1 lowest priority last");
    do_claim(0, "R3 claimed not re-pended");
    chk(irq_o, 0, "R3 irq low all claimed");
    do_complete(3);
    do_claim(3, "R5 level re-forward");
    line_i[2] = 1'b0;
    do_complete(3);
    do_claim(0, "R6 dropped line no refire");
    do_complete(2);
    do_claim(2, "R5 level re-forward id2");
    line_i[1] = 1'b0;
    do_complete(2);

    // stray completions (source 1 still claimed, line high)
    do_complete(6);
    do_complete(0);
    do_claim(0, "R8 stray completion ignored");
    do_complete(1);
    do_claim(1, "R8 real completion releases");
    line_i[0] = 1'b0;
    do_complete(1);
    do_claim(0, "R6 idle after release");

    // edge source 4
    pulse(4); pulse(4);
    do_claim(4, "R7 edge request");
    do_claim(0, "R7 edges merged while pending");
    pulse(4); pulse(4);
    do_claim(0, "R7 edges deferred while claimed");
    do_complete(4);
    do_claim(4, "R7 deferred forwarded");
    do_claim(0, "R7 single deferred request");
    do_complete(4);
    do_claim(0, "R7 nothing held");

    // edge line held high fires once
    line_i[5] = 1'b1; tick();
    do_claim(6, "R7 edge held high");
    do_complete(6);
    do_claim(0, "R7 held high no refire");
    line_i[5] = 1'b0;
    do_complete(6);

    // rising edge in the claim cycle of the same edge source
    pulse(7);
    chk(irq_o, 1, "R9 edge pending irq");
    exp_q.push_back(7); tag_q.push_back("R10 edge claim");
    claim_i = 1'b1; line_i[6] = 1'b1;
    tick();
    claim_i = 1'b0; line_i[6] = 1'b0;
    tick();
    do_claim(0, "R10 coincident edge deferred");
    do_complete(7);
    do_claim(7, "R10 coincident edge delivered");
    do_complete(7);

    // level line rising in the claim cycle of the same level source
    pulse(3);
    exp_q.push_back(3); tag_q.push_back("R10 level claim");
    claim_i = 1'b1; line_i[2] = 1'b1;
    tick();
    claim_i = 1'b0;
    do_claim(0, "R10 level not pending while claimed");
    do_complete(3);
    do_claim(3, "R10 level re-raised at completion");
    line_i[2] = 1'b0;
    do_complete(3);
    chk(irq_o, 0, "R9 irq low at end");

    tick();
    finish_run();
  end
endmodule